// File: doc/BRIEF.md
# Option configuration loader

After the external reset is released, this block keeps the processor halted and reads a small set of option bytes from a reserved region at the top of program memory. It turns those bytes into per-pin settings for three 8-bit ports: whether each pin drives push-pull or open drain, and whether its pull-up may be switched on. Once a fixed hold interval has passed, it releases the processor, which then starts fetching at address zero. Memory, the processor and the pad circuits sit outside the block.

The loader reads the memory through a simple synchronous port. It drives one address and a read strobe per cycle, and the memory returns the data one cycle later. Four option bytes are read: the output-type bytes for port 0, port 1 and port 3, and then a byte that holds the port 0 pull-up bits. All other bytes in the region are never read. A pin set to open drain never gets a pull-up.

Top module: `opt_cfg_loader`

## Requirements
- R1: While `rst_n` is low at a clock edge, every type and pull-up output clears to 0 after that edge (0 means open drain, no pull-up), and `cpu_run`, `cfg_done` and `mem_rd` go low.
- R2: After the first edge with `rst_n` high, `mem_rd` is high for exactly four consecutive cycles, with `mem_addr` = 7F00h, 7F01h, 7F02h, 7F03h in that order. No other address is ever read.
- R3: Data returned on `mem_data` in the cycle after a read cycle is taken into the configuration at the next edge. The port 0 type byte is visible after the third edge with `rst_n` high, and not before.
- R4: Bit i of the byte at 7F00h sets `p0_cmos[i]`. A 1 selects push-pull and a 0 selects open drain.
- R5: Bit i of the byte at 7F01h sets `p1_cmos[i]`, and bit i of the byte at 7F02h sets `p3_cmos[i]`, with the same encoding as R4.
- R6: Bit 0 of the byte at 7F03h enables the pull-up on port 0 pins 3..0, and bit 1 enables it on pins 7..4. Bits 7..2 are ignored. `p0_pu[i]` is 1 only when its nibble bit is 1 and `p0_cmos[i]` is 1.
- R7: `p1_pu[i]` and `p3_pu[i]` are 1 exactly when the matching type bit selects push-pull. An open-drain pin always has its pull-up forced low.
- R8: `cpu_run` and `cfg_done` rise together, exactly `HOLD_CYCLES` edges after reset release (counting the first edge with `rst_n` high as one). They then stay high until the next reset.
- R9: All option bytes are captured before release. The configuration does not change while `cfg_done` is high.
- R10: Asserting reset in the middle of the fetch or the hold restarts both from the beginning and uses the memory contents present after the new release.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low external reset |
| mem_addr | output | 15 | Program memory read address |
| mem_rd | output | 1 | Read strobe |
| mem_data | input | 8 | Read data, valid one cycle after the strobe |
| cpu_run | output | 1 | High releases the processor |
| cfg_done | output | 1 | Configuration applied |
| p0_cmos | output | 8 | Port 0 output type per pin, 1 = push-pull |
| p0_pu | output | 8 | Port 0 pull-up enable per pin |
| p1_cmos | output | 8 | Port 1 output type per pin |
| p1_pu | output | 8 | Port 1 pull-up allowed per pin |
| p3_cmos | output | 8 | Port 3 output type per pin |
| p3_pu | output | 8 | Port 3 pull-up allowed per pin |

## Verification
A wrong internal state shows up at the ports within one cycle of its cause. An issue counter that is off shows as a wrong `mem_addr` or a fifth strobe. A capture index that is off puts a byte on the wrong port at the third to sixth edge. A hold counter that is wrong moves the rise of `cpu_run` away from edge `HOLD_CYCLES`. The bench keeps a count of edges since release and checks every output against the expected value on every cycle. Because of this, any of these faults is reported in the cycle it first appears. Resets during the fetch and one cycle before release check that no stale count or byte survives.

// File: rtl/opt_cfg_pkg.sv
// Shared constants for the option configuration loader.
// Assumes 8-pin ports and one pull-up byte after the type bytes.
package opt_cfg_pkg;
    localparam int OPT_W        = 8;
    localparam int N_TYPE_BYTES = 3;
    localparam int N_OPT_BYTES  = N_TYPE_BYTES + 1;
    localparam int NIB_BITS     = OPT_W / 4;
    localparam int IDX_W        = $clog2(N_OPT_BYTES + 1);
    typedef logic [OPT_W-1:0] pin_vec_t;
endpackage

// File: rtl/opt_fetch_seq.sv
// Issues one read per cycle over the option bytes after reset release.
// It also marks the returned data as valid one cycle later.
// Assumes the memory read latency is exactly one cycle.
module opt_fetch_seq
    import opt_cfg_pkg::*;
#(
    parameter int ADDR_W = 15,
    parameter int BASE   = 32'h7F00
) (
    input  logic              clk,
    input  logic              rst_n,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_rd,
    output logic              cap_vld,
    output logic [IDX_W-1:0]  cap_idx,
    output logic              all_captured
);
    logic [IDX_W-1:0] issue_cnt;

    // Address issue: one strobe per option byte, in ascending order.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            issue_cnt <= '0;
            mem_rd    <= 1'b0;
            mem_addr  <= ADDR_W'(BASE);
        end else if (int'(issue_cnt) < N_OPT_BYTES) begin
            issue_cnt <= issue_cnt + 1'b1;
            mem_rd    <= 1'b1;
            mem_addr  <= ADDR_W'(BASE + int'(issue_cnt));
        end else begin
            mem_rd    <= 1'b0;
        end
    end

    // Capture tracking: data returns one cycle after the strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cap_vld      <= 1'b0;
            cap_idx      <= '0;
            all_captured <= 1'b0;
        end else begin
            cap_vld <= mem_rd;
            cap_idx <= IDX_W'(int'(mem_addr) - BASE);
            if (cap_vld && int'(cap_idx) == N_OPT_BYTES - 1)
                all_captured <= 1'b1;
        end
    end

    assert_rd_window_R2: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd |-> (int'(mem_addr) >= BASE && int'(mem_addr) < BASE + N_OPT_BYTES));

    assert_rd_ascending_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd && $past(mem_rd)) |-> (mem_addr == $past(mem_addr) + 1'b1));
endmodule

// File: rtl/opt_hold_timer.sv
// Counts the post-reset hold interval and raises a sticky release flag.
// The release flag rises at edge HOLD_CYCLES after reset release.
module opt_hold_timer #(
    parameter int HOLD_CYCLES = 375000
) (
    input  logic clk,
    input  logic rst_n,
    output logic run
);
    localparam int CW = $clog2(HOLD_CYCLES + 1);
    logic [CW-1:0] cnt;

    // Hold count: advances until release, then freezes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
            run <= 1'b0;
        end else if (!run) begin
            cnt <= cnt + 1'b1;
            run <= (cnt == CW'(HOLD_CYCLES - 1));
        end
    end

    assert_release_at_limit_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(run) |-> (cnt == CW'(HOLD_CYCLES)));

    assert_release_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        run |=> run);
endmodule

// File: rtl/opt_port_decode.sv
// Stores the captured option bytes and derives pull-up enables.
// Port slot 0 takes nibble-wide pull-up bits; the other slots allow a pull-up on push-pull pins.
// Assumes captures arrive with an index in 0..N_OPT_BYTES-1.
module opt_port_decode
    import opt_cfg_pkg::*;
(
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              cap_vld,
    input  logic [IDX_W-1:0]                  cap_idx,
    input  logic [OPT_W-1:0]                  cap_data,
    output logic [N_TYPE_BYTES-1:0][OPT_W-1:0] type_q,
    output logic [N_TYPE_BYTES-1:0][OPT_W-1:0] pu_q
);
    logic [NIB_BITS-1:0] nib_q;

    // Pull-up nibble bits: low bits of the last option byte.
    always_ff @(posedge clk) begin
        if (!rst_n)
            nib_q <= '0;
        else if (cap_vld && int'(cap_idx) == N_TYPE_BYTES)
            nib_q <= cap_data[NIB_BITS-1:0];
    end

    for (genvar g = 0; g < N_TYPE_BYTES; g++) begin : g_port
        logic [OPT_W-1:0] r;
        logic [OPT_W-1:0] pu_mask;

        // Output type register for this port slot.
        always_ff @(posedge clk) begin
            if (!rst_n)
                r <= '0;
            else if (cap_vld && int'(cap_idx) == g)
                r <= cap_data;
        end

        if (g == 0) begin : g_nibble
            // Expand each nibble bit over its four pins.
            always_comb begin
                for (int b = 0; b < OPT_W; b++)
                    pu_mask[b] = nib_q[b / 4];
            end
        end else begin : g_bitwise
            assign pu_mask = '1;
        end

        assign type_q[g] = r;
        assign pu_q[g]   = pu_mask & r;
    end

    assert_open_drain_no_pullup_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (pu_q[0] & ~type_q[0]) == '0);
endmodule

// File: rtl/opt_cfg_loader.sv
// Top level: holds the processor after reset, fetches option bytes and drives the port configuration.
// Assumes HOLD_CYCLES is long enough for all captures (N_OPT_BYTES + 2 edges).
module opt_cfg_loader
    import opt_cfg_pkg::*;
#(
    parameter int ADDR_W      = 15,
    parameter int OPT_BASE    = 32'h7F00,
    parameter int HOLD_CYCLES = 375000
) (
    input  logic              clk,
    input  logic              rst_n,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_rd,
    input  logic [7:0]        mem_data,
    output logic              cpu_run,
    output logic              cfg_done,
    output logic [7:0]        p0_cmos,
    output logic [7:0]        p0_pu,
    output logic [7:0]        p1_cmos,
    output logic [7:0]        p1_pu,
    output logic [7:0]        p3_cmos,
    output logic [7:0]        p3_pu
);
    logic                              cap_vld;
    logic [IDX_W-1:0]                  cap_idx;
    logic                              all_captured;
    logic                              run;
    logic [N_TYPE_BYTES-1:0][OPT_W-1:0] type_q;
    logic [N_TYPE_BYTES-1:0][OPT_W-1:0] pu_q;

    initial assert (HOLD_CYCLES >= N_OPT_BYTES + 2)
        else $error("HOLD_CYCLES too short for the option fetch");

    opt_fetch_seq #(.ADDR_W(ADDR_W), .BASE(OPT_BASE)) u_fetch (
        .clk(clk), .rst_n(rst_n), .mem_addr(mem_addr), .mem_rd(mem_rd),
        .cap_vld(cap_vld), .cap_idx(cap_idx), .all_captured(all_captured)
    );

    opt_hold_timer #(.HOLD_CYCLES(HOLD_CYCLES)) u_timer (
        .clk(clk), .rst_n(rst_n), .run(run)
    );

    opt_port_decode u_decode (
        .clk(clk), .rst_n(rst_n), .cap_vld(cap_vld), .cap_idx(cap_idx),
        .cap_data(mem_data), .type_q(type_q), .pu_q(pu_q)
    );

    assign cpu_run  = run;
    assign cfg_done = run;
    assign p0_cmos  = type_q[0];
    assign p0_pu    = pu_q[0];
    assign p1_cmos  = type_q[1];
    assign p1_pu    = pu_q[1];
    assign p3_cmos  = type_q[2];
    assign p3_pu    = pu_q[2];

    assert_fetch_before_release_R9: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_run |-> all_captured);

    assert_cfg_frozen_R9: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_done |=> ($stable(p0_cmos) && $stable(p1_cmos) && $stable(p3_cmos) && $stable(p0_pu)));

    assert_no_read_after_release_R2: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_run |-> !mem_rd);
endmodule

// File: tb/sim_opt_cfg_loader.sv
// Bench: behavioural memory and edge-count reference model, compared on every falling edge.
module sim_opt_cfg_loader;
    localparam int HOLD = 12;
    localparam logic [14:0] BASE = 15'h7F00;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [14:0] mem_addr;
    logic        mem_rd;
    logic [7:0]  mem_data = 8'h00;
    logic        cpu_run, cfg_done;
    logic [7:0]  p0_cmos, p0_pu, p1_cmos, p1_pu, p3_cmos, p3_pu;

    logic [7:0] img [4];
    int n = 0;
    int checks = 0;
    int errors = 0;
    bit checking = 1'b0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    opt_cfg_loader #(.HOLD_CYCLES(HOLD)) u0 (
        .clk(clk), .rst_n(rst_n), .mem_addr(mem_addr), .mem_rd(mem_rd), .mem_data(mem_data),
        .cpu_run(cpu_run), .cfg_done(cfg_done), .p0_cmos(p0_cmos), .p0_pu(p0_pu),
        .p1_cmos(p1_cmos), .p1_pu(p1_pu), .p3_cmos(p3_cmos), .p3_pu(p3_pu)
    );

    function automatic logic [7:0] mem_at(input logic [14:0] a);
        if (a[14:2] == BASE[14:2]) return img[a[1:0]];
        return 8'h5A;
    endfunction

    // Behavioural memory with one-cycle latency.
    always @(posedge clk) if (mem_rd) mem_data <= mem_at(mem_addr);

    // Reference: edges with reset high since the last reset.
    always @(posedge clk) n <= !rst_n ? 0 : (n < 1000000 ? n + 1 : n);

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h (n=%0d)", tag, act, exp, n);
        end
    endtask

    function automatic logic [7:0] exp_type(input int k);
        return (n >= k + 3) ? img[k] : 8'h00;
    endfunction

    // Per-cycle comparison against the reference model.
    always @(negedge clk) if (checking) begin
        logic [7:0] nib_mask;
        string t;
        t = (n == 0) ? "R1" : "R4";
        nib_mask = (n >= 6) ? {{4{img[3][1]}}, {4{img[3][0]}}} : 8'h00;
        chk((n == 0) ? "R1" : "R8", {31'd0, cpu_run}, {31'd0, n >= HOLD});
        chk((n == 0) ? "R1" : "R8", {31'd0, cfg_done}, {31'd0, n >= HOLD});
        chk((n == 0) ? "R1" : "R2", {31'd0, mem_rd}, {31'd0, n >= 1 && n <= 4});
        if (n >= 1 && n <= 4) chk("R2", {17'd0, mem_addr}, {17'd0, BASE + 15'(n - 1)});
        chk(t, {24'd0, p0_cmos}, {24'd0, exp_type(0)});
        chk((n == 0) ? "R1" : "R5", {24'd0, p1_cmos}, {24'd0, exp_type(1)});
        chk((n == 0) ? "R1" : "R5", {24'd0, p3_cmos}, {24'd0, exp_type(2)});
        chk((n == 0) ? "R1" : "R6", {24'd0, p0_pu}, {24'd0, nib_mask & exp_type(0)});
        chk((n == 0) ? "R1" : "R7", {24'd0, p1_pu}, {24'd0, exp_type(1)});
        chk((n == 0) ? "R1" : "R7", {24'd0, p3_pu}, {24'd0, exp_type(2)});
        if (n > HOLD) chk("R9", {24'd0, p0_cmos}, {24'd0, img[0]});
    end

    task automatic cycles(input int c);
        repeat (c) @(negedge clk);
    endtask

    task automatic load(input logic [7:0] a, input logic [7:0] b, input logic [7:0] c, input logic [7:0] d);
        img[0] = a; img[1] = b; img[2] = c; img[3] = d;
    endtask

    task automatic do_reset(input int c);
        rst_n = 1'b0;
        cycles(c);
    endtask

    initial begin
        load(8'h00, 8'h00, 8'h00, 8'h00);
        cycles(3);
        checking = 1'b1;
        // R1 reset state already compared each cycle; explicit one here.
        chk("R1", {31'd0, cpu_run}, 32'd0);

        // Case A: mixed bytes, junk in upper pull-up bits, R3 timing.
        load(8'hA5, 8'h3C, 8'hF0, 8'hFE);
        rst_n = 1'b1;
        cycles(2);
        chk("R3", {24'd0, p0_cmos}, 32'd0);
        cycles(1);
        chk("R3", {24'd0, p0_cmos}, 32'hA5);
        cycles(HOLD + 8);
        chk("R6", {24'd0, p0_pu}, 32'hA0);

        // Case B: everything push-pull, only low nibble pull-up.
        do_reset(2);
        load(8'hFF, 8'hFF, 8'hFF, 8'h01);
        rst_n = 1'b1;
        cycles(HOLD + 5);
        chk("R6", {24'd0, p0_pu}, 32'h0F);

        // Case C: reset in the middle of the fetch, new image after restart.
        do_reset(2);
        load(8'h0F, 8'h81, 8'h7E, 8'h03);
        rst_n = 1'b1;
        cycles(4);
        do_reset(1);
        load(8'hFF, 8'h00, 8'h55, 8'h03);
        rst_n = 1'b1;
        cycles(1);
        chk("R10", {17'd0, mem_addr}, {17'd0, BASE});
        cycles(HOLD + 4);
        chk("R10", {24'd0, p3_cmos}, 32'h55);

        // Case D: reset one cycle before release restarts the hold.
        do_reset(2);
        load(8'h12, 8'h34, 8'h56, 8'h02);
        rst_n = 1'b1;
        cycles(HOLD - 1);
        do_reset(1);
        chk("R10", {31'd0, cpu_run}, 32'd0);
        rst_n = 1'b1;
        cycles(HOLD + 3);

        // Case E: all open drain with pull-up bits set: pull-ups forced off.
        do_reset(2);
        load(8'h00, 8'h00, 8'h00, 8'h03);
        rst_n = 1'b1;
        cycles(HOLD + 3);
        chk("R7", {24'd0, p0_pu | p1_pu | p3_pu}, 32'd0);

        checking = 1'b0;
        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        #(8 * 150000);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule